// File: doc/BRIEF.md
# Single-Shot Edge Capture Timer

A 16-bit up-counter with an 8-bit control and status register, meant to time a single-slope conversion. Software starts a count by setting a run bit. The count then advances once per system clock. The first falling edge on an external comparator line stops the counter, clears the run bit and raises a pending flag. The frozen count is then read back one byte at a time over a small byte-wide register bus.

A mode bit selects what a start does to the count. With mode 0, a start clears the count. With mode 1, a start keeps whatever value software wrote into the count bytes, which turns the block into a programmable delay counter when it is used with the overflow flag. The pending and overflow flags are sticky and drive one shared interrupt line.

Top module: `ecap_timer`

## Requirements
- R1: The counter is 16 bits wide. Bus address 1 holds its low byte and address 2 its high byte; both can be read and written, and a byte write loads that byte on the next clock edge. While the run bit is 1 and no capture happens, the count rises by one on every clock edge.
- R2: After reset the count is 0x0000, every control bit is 0 and the interrupt output is low.
- R3: Writing the control register with bit 3 (run) set to 1 starts counting. Writing it with bit 3 at 0 stops the counter: the count at that edge is kept and does not change afterwards.
- R4: The capture input passes through two synchronizing flops and then a falling-edge detector. Suppose the input is first sampled low at clock edge k while running. The last increment then happens at edge k+1, and at edge k+2 the count holds, run clears and pending (bit 1) sets.
- R5: A falling edge on the capture input while run is 0 is ignored. The count is unchanged, pending stays 0 and the interrupt stays low.
- R6: Control bit 4 (mode) is taken from the same write that sets run. With mode 0, a start loads the count with 0x0000. With mode 1, a start keeps the present count, so a preloaded value is used.
- R7: If the count wraps from 0xFFFF to 0x0000 while running, overflow (bit 2) sets. The counter keeps counting after the wrap.
- R8: Pending and overflow are cleared only by a control write with that bit at 0. Writing 1 to either flag has no effect. A hardware set in the same cycle as a clear wins.
- R9: The interrupt output is registered. It equals enable (bit 0) AND (pending OR overflow), and it changes on the same edge as the flags.
- R10: If a write that sets run lands on the same edge as a capture, the capture wins. Run ends at 0, pending is set and the count holds.
- R11: Control bits 7 to 5 are reserved and always read 0. The read data is registered and shows the addressed register one clock after the address is presented. Address 0 is the control register and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count low, 2 count high |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_in | input | 1 | Asynchronous comparator input; the falling edge captures |
| irq | output | 1 | Shared interrupt for capture and overflow |

## Verification
A wrong run or edge-detect state shows up directly in the frozen count. Every cycle of latency error moves the captured value by exactly one. A capture sweep over many start-to-edge delays therefore exposes it within a few clocks of the edge. A stuck or lost flag appears on the next control read, and again on the interrupt pin in the same cycle as the flag. Mode and race faults show up as a count that is off by the preload or as a run bit that stays set. Both can be read back on the first access after the event.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int CTL_IE   = 0;
  localparam int CTL_PEND = 1;
  localparam int CTL_OVF  = 2;
  localparam int CTL_RUN  = 3;
  localparam int CTL_MODE = 4;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CNT0 = 1;

  typedef struct packed {
    logic mode;
    logic run;
    logic ovf;
    logic pend;
    logic ie;
  } ctl_t;
endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[STAGES-1];
  end

  assign fall = last & ~chain[STAGES-1];
endmodule

// File: rtl/ecap_counter.sv
module ecap_counter #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inc_en,
  input  logic                      clr,
  input  logic [CNT_W/BYTE_W-1:0]   byte_we,
  input  logic [BYTE_W-1:0]         byte_wd,
  output logic [CNT_W-1:0]          cnt,
  output logic                      at_max
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt_plus;
  logic             any_we;

  assign cnt_plus = cnt + CNT_W'(1);
  assign any_we   = |byte_we;
  assign at_max   = &cnt;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             cnt[b*BYTE_W +: BYTE_W] <= '0;
      else if (byte_we[b]) cnt[b*BYTE_W +: BYTE_W] <= byte_wd;
      else if (any_we)     cnt[b*BYTE_W +: BYTE_W] <= cnt[b*BYTE_W +: BYTE_W];
      else if (clr)        cnt[b*BYTE_W +: BYTE_W] <= '0;
      else if (inc_en)     cnt[b*BYTE_W +: BYTE_W] <= cnt_plus[b*BYTE_W +: BYTE_W];
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !clr && !any_we) |=> (cnt == $past(cnt) + CNT_W'(1))); // R1
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!inc_en && !clr && !any_we) |=> $stable(cnt)); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr && !any_we) |=> (cnt == '0)); // R6
endmodule

// File: rtl/ecap_ctl.sv
module ecap_ctl
  import ecap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wd,
  input  logic              fall,
  input  logic              cnt_at_max,
  output ctl_t              st,
  output logic              inc_en,
  output logic              start_clr,
  output logic              irq
);
  ctl_t st_d;
  logic cap_evt;
  logic sw_start;
  logic wrap;

  assign cap_evt   = st.run & fall;
  assign sw_start  = ctrl_we & wd[CTL_RUN] & ~st.run;
  assign inc_en    = st.run & ~cap_evt;
  assign start_clr = sw_start & ~wd[CTL_MODE] & ~cap_evt;
  assign wrap      = inc_en & cnt_at_max;

  always_comb begin
    st_d = st;
    if (ctrl_we) begin
      st_d.mode = wd[CTL_MODE];
      st_d.ie   = wd[CTL_IE];
      st_d.run  = wd[CTL_RUN];
      if (!wd[CTL_PEND]) st_d.pend = 1'b0;
      if (!wd[CTL_OVF])  st_d.ovf  = 1'b0;
    end
    if (cap_evt) begin
      st_d.run  = 1'b0;
      st_d.pend = 1'b1;
    end
    if (wrap) st_d.ovf = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= '0;
      irq <= 1'b0;
    end else begin
      st  <= st_d;
      irq <= st_d.ie & (st_d.pend | st_d.ovf);
    end
  end

  AST_CAPTURE_STOPS: assert property (@(posedge clk) disable iff (rst)
    (st.run && fall) |=> (!st.run && st.pend)); // R10
  AST_IGNORE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(st.pend) |-> $past(st.run)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st.ovf && !(ctrl_we && !wd[CTL_OVF])) |=> st.ovf); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st.pend && !(ctrl_we && !wd[CTL_PEND])) |=> st.pend); // R8
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq == (st.ie && (st.pend || st.ovf))); // R9
endmodule

// File: rtl/ecap_timer.sv
module ecap_timer
  import ecap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_in,
  output logic              irq
);
  localparam int NB = CNT_W / DATA_W;

  ctl_t             st;
  logic             fall;
  logic             inc_en;
  logic             start_clr;
  logic             at_max;
  logic             ctrl_we;
  logic [NB-1:0]    byte_we;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] ctl_img;

  assign ctrl_we = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign byte_we[b] = bus_we && (bus_addr == ADDR_W'(ADDR_CNT0 + b));
  end

  ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cap_in), .fall(fall)
  );

  ecap_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .wd(bus_wdata),
    .fall(fall), .cnt_at_max(at_max), .st(st), .inc_en(inc_en),
    .start_clr(start_clr), .irq(irq)
  );

  ecap_counter #(.CNT_W(CNT_W), .BYTE_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .inc_en(inc_en), .clr(start_clr),
    .byte_we(byte_we), .byte_wd(bus_wdata), .cnt(cnt), .at_max(at_max)
  );

  always_comb begin
    ctl_img = '0;
    ctl_img[CTL_IE]   = st.ie;
    ctl_img[CTL_PEND] = st.pend;
    ctl_img[CTL_OVF]  = st.ovf;
    ctl_img[CTL_RUN]  = st.run;
    ctl_img[CTL_MODE] = st.mode;
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(ADDR_CTRL)) rd_next = ctl_img;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == ADDR_W'(ADDR_CNT0 + b)) rd_next = cnt[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(ADDR_CTRL)) |-> (bus_rdata[DATA_W-1:CTL_MODE+1] == '0)); // R11
  AST_NO_RUN_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (st.run && fall) |=> $stable(cnt)); // R4
endmodule

// File: tb/ecap_timer_test.sv
module ecap_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_in = 1'b1;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  ecap_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic rd_cnt(output int v);
    int lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic settle();
    cap_in = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v, c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    rd(2'd0, v); chk("R2 ctrl", v, 0);
    rd_cnt(c);   chk("R2 count", c, 0);
    chk("R2 irq", int'(irq), 0);

    // R11 reserved bits and unused address
    wr(2'd0, 8'hE0); rd(2'd0, v); chk("R11 reserved", v, 0);
    rd(2'd3, v); chk("R11 unused addr", v, 0);

    // R8 writing 1 to flags does nothing
    wr(2'd0, 8'h06); rd(2'd0, v); chk("R8 set-by-write", v, 0);

    // R1 byte access
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); rd_cnt(c); chk("R1 byte rw", c, 16'h3CA5);

    // R5 edge while stopped is ignored
    wr(2'd0, 8'h01);
    cap_in = 1'b0; repeat (5) @(negedge clk); settle();
    rd(2'd0, v); chk("R5 ctrl", v, 8'h01);
    rd_cnt(c);   chk("R5 count", c, 16'h3CA5);
    chk("R5 irq", int'(irq), 0);

    // R4 capture sweep, mode 0 with interrupt on
    for (int w = 0; w < 24; w++) begin
      wr(2'd0, 8'h09);
      repeat (w) @(negedge clk);
      cap_in = 1'b0;
      repeat (6) @(negedge clk);
      rd_cnt(c); chk("R4 captured count", c, w + 2);
      rd(2'd0, v); chk("R4 ctrl after capture", v, 8'h03);
      chk("R9 irq on capture", int'(irq), 1);
      settle();
      wr(2'd0, 8'h01);
      rd(2'd0, v); chk("R8 pend cleared", v, 8'h01);
      chk("R9 irq after clear", int'(irq), 0);
    end

    // R3 stop freezes, mode 0 start clears preload (R6)
    for (int w = 0; w < 12; w += 3) begin
      wr(2'd1, 8'h34); wr(2'd2, 8'h12);
      wr(2'd0, 8'h08);
      repeat (w) @(negedge clk);
      wr(2'd0, 8'h06);
      rd_cnt(c); chk("R3 stop value", c, w + 1);
      repeat (7) @(negedge clk);
      rd_cnt(v); chk("R3 frozen", v, w + 1);
    end

    // R6 mode 1 keeps preload
    wr(2'd1, 8'h00); wr(2'd2, 8'h50);
    wr(2'd0, 8'h18);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h16);
    rd_cnt(c); chk("R6 preload kept", c, 16'h5004);

    // R7 overflow with wrap, interrupt off then on
    wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
    wr(2'd0, 8'h18);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h16);
    rd_cnt(c); chk("R7 wrapped count", c, 16'h0004);
    rd(2'd0, v); chk("R7 ovf flag", v, 8'h14);
    chk("R9 irq masked", int'(irq), 0);
    wr(2'd0, 8'h15); @(negedge clk);
    chk("R9 irq ovf", int'(irq), 1);
    wr(2'd0, 8'h11);
    rd(2'd0, v); chk("R8 ovf cleared", v, 8'h11);
    chk("R9 irq cleared", int'(irq), 0);

    // R10 start write on the capture edge
    for (int w = 1; w < 6; w++) begin
      wr(2'd0, 8'h09);
      repeat (w) @(negedge clk);
      cap_in = 1'b0;
      repeat (2) @(negedge clk);
      wr(2'd0, 8'h19);
      rd(2'd0, v); chk("R10 ctrl after race", v, 8'h13);
      rd_cnt(c);   chk("R10 count held", c, w + 2);
      settle();
      wr(2'd0, 8'h01);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule